// File: doc/BRIEF.md
# CPU Bus Stall and Release Controller

This block sits between an 8-bit CPU core and its external bus pads. It decides when the core must freeze because a slow target has pulled the ready line low. It also decides when the core's address, data and read/write drivers must let go of the bus so that another master can use it. The block does not carry the address or data values. It produces one output enable per pad for the 16-bit address bus and the 8-bit data bus, an enable and a level for the read/write line, and a stall flag for the core pipeline.

Time is counted in half-cycles of the system clock, one `clk` period each. `phi2_i` is high in the phase-2 half and low in the phase-1 half. The core reports the kind of bus cycle it is running on `cyc_wr_i`, where 1 means write and 0 means read. A ready drop freezes only read cycles; a write that has started always runs to the end. A low `bus_grant_i` releases the pads in the same half-cycle, whatever ready is doing. When the grant comes back, the drivers stay off until the next phase 1 begins, so two masters never drive the bus at the same time.

Top module: `cpu_bus_arbiter`

## Requirements
- R1: After synchronous reset `stall_o` is 0 and the block owns the bus, so all enables follow `bus_grant_i` from the first cycle after reset.
- R2: A clock edge in phase 1 (`phi2_i`=0) with `ready_i`=0 and a read cycle (`cyc_wr_i`=0) makes `stall_o` 1 from the next cycle on.
- R3: A clock edge in phase 1 during a write cycle (`cyc_wr_i`=1) makes `stall_o` 0, whatever the value of `ready_i`, so a write is never frozen.
- R4: `stall_o` does not change on a clock edge in phase 2 (`phi2_i`=1).
- R5: A clock edge in phase 1 with `ready_i`=1 clears `stall_o`, so the frozen read completes in the phase 2 that follows, with no extra cycle.
- R6: While `bus_grant_i` is 0, every bit of `addr_oe` and `data_oe` is 0 and `rw_oe` is 0 in that same cycle, whatever the value of `ready_i`.
- R7: After `bus_grant_i` has been 0, the enables stay 0 until a clock edge in phase 2 with `bus_grant_i`=1 has passed. They turn on at the start of the phase 1 that follows that edge.
- R8: `rw_o` is 1 for a read cycle and 0 for a write cycle.
- R9: Every bit of `data_oe` is 1 only when the bus is owned and granted, the cycle is a write, and `phi2_i` is 1. In all other cases every bit is 0.
- R10: All bits of `addr_oe` are equal to `rw_oe`: 1 when the bus is owned and granted, 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| ready_i | input | 1 | Target ready; low asks the core to freeze at a read |
| bus_grant_i | input | 1 | High while this core may drive the bus |
| phi2_i | input | 1 | High in the phase-2 half, low in phase 1 |
| cyc_wr_i | input | 1 | Core cycle type: 1 write, 0 read |
| addr_oe | output | 16 | Per-pad address drive enables |
| data_oe | output | 8 | Per-pad data drive enables |
| rw_oe | output | 1 | Read/write pad drive enable |
| rw_o | output | 1 | Read/write level: 1 read, 0 write |
| stall_o | output | 1 | Freeze request to the core pipeline |

## Verification
The bench drops ready during a write cycle and checks that no stall appears. A design that stalled on any cycle type would freeze the write halfway through. It raises ready again in the half-cycle just before phase 2 and expects the stall to clear at once; a design with an extra register stage would add a wasted bus cycle. It also drops and raises the grant in phase 1 and in phase 2. Re-enabling in the wrong half, or waiting on ready, would turn the drivers on while another master still owns the bus, or hold them off for too long. Random runs mix all four inputs against a reference model in the bench.

// File: rtl/cpu_bus_pkg.sv
package cpu_bus_pkg;

    typedef enum logic {
        CYC_READ  = 1'b0,
        CYC_WRITE = 1'b1
    } cyc_e;

    typedef struct packed {
        logic addr;
        logic data;
        logic rw;
    } bus_en_t;

    function automatic logic rw_level(input cyc_e c);
        return (c == CYC_READ);
    endfunction

    function automatic bus_en_t pad_enables(input logic owned, input cyc_e c, input logic phi2);
        bus_en_t e;
        e.addr = owned;
        e.rw   = owned;
        e.data = owned && (c == CYC_WRITE) && phi2;
        return e;
    endfunction

endpackage

// File: rtl/cpu_bus_stall.sv
module cpu_bus_stall
    import cpu_bus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic phi2_i,
    input  logic ready_i,
    input  cyc_e cyc_i,
    output logic stall_o
);

    logic stall_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_q <= 1'b0;
        end else if (!phi2_i) begin
            stall_q <= !ready_i && (cyc_i == CYC_READ);
        end
    end

    assign stall_o = stall_q;

    a_r2_stall_on_read: assert property (@(posedge clk) disable iff (rst)
        (!phi2_i && !ready_i && cyc_i == CYC_READ) |=> stall_o);

    a_r3_write_runs: assert property (@(posedge clk) disable iff (rst)
        (!phi2_i && cyc_i == CYC_WRITE) |=> !stall_o);

    a_r4_hold_in_phi2: assert property (@(posedge clk) disable iff (rst)
        phi2_i |=> $stable(stall_o));

    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        (!phi2_i && ready_i) |=> !stall_o);

endmodule

// File: rtl/cpu_bus_grant.sv
module cpu_bus_grant (
    input  logic clk,
    input  logic rst,
    input  logic phi2_i,
    input  logic grant_i,
    output logic owned_o
);

    logic own_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q <= 1'b1;
        end else if (!grant_i) begin
            own_q <= 1'b0;
        end else if (phi2_i) begin
            own_q <= 1'b1;
        end
    end

    assign owned_o = own_q && grant_i;

    a_r6_release_now: assert property (@(posedge clk) disable iff (rst)
        !grant_i |-> !owned_o);

    a_r7_no_early_return: assert property (@(posedge clk) disable iff (rst)
        (!own_q && !phi2_i) |=> !own_q);

    a_r7_return_after_phi2: assert property (@(posedge clk) disable iff (rst)
        (grant_i && phi2_i) |=> own_q);

endmodule

// File: rtl/cpu_bus_arbiter.sv
module cpu_bus_arbiter
    import cpu_bus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ready_i,
    input  logic              bus_grant_i,
    input  logic              phi2_i,
    input  logic              cyc_wr_i,
    output logic [ADDR_W-1:0] addr_oe,
    output logic [DATA_W-1:0] data_oe,
    output logic              rw_oe,
    output logic              rw_o,
    output logic              stall_o
);

    cyc_e    cyc;
    logic    owned;
    bus_en_t en;

    assign cyc = cyc_e'(cyc_wr_i);

    cpu_bus_stall u_stall (
        .clk     (clk),
        .rst     (rst),
        .phi2_i  (phi2_i),
        .ready_i (ready_i),
        .cyc_i   (cyc),
        .stall_o (stall_o)
    );

    cpu_bus_grant u_grant (
        .clk     (clk),
        .rst     (rst),
        .phi2_i  (phi2_i),
        .grant_i (bus_grant_i),
        .owned_o (owned)
    );

    assign en    = pad_enables(owned, cyc, phi2_i);
    assign rw_oe = en.rw;
    assign rw_o  = rw_level(cyc);

    for (genvar a = 0; a < ADDR_W; a++) begin : g_addr_pad
        assign addr_oe[a] = en.addr;
    end

    for (genvar d = 0; d < DATA_W; d++) begin : g_data_pad
        assign data_oe[d] = en.data;
    end

    a_r9_data_in_phi2_write: assert property (@(posedge clk) disable iff (rst)
        (data_oe != '0) |-> (phi2_i && cyc_wr_i && bus_grant_i));

    a_r6_no_drive_without_grant: assert property (@(posedge clk) disable iff (rst)
        !bus_grant_i |-> (addr_oe == '0 && data_oe == '0 && !rw_oe));

endmodule

// File: tb/tb_cpu_bus_arbiter.sv
module tb_cpu_bus_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ready_i = 1'b1, bus_grant_i = 1'b1, phi2_i = 1'b0, cyc_wr_i = 1'b0;
    logic [AW-1:0] addr_oe;
    logic [DW-1:0] data_oe;
    logic rw_oe, rw_o, stall_o;

    int checks = 0;
    int errors = 0;
    logic m_stall = 1'b0;
    logic m_own = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_bus_arbiter #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .ready_i(ready_i), .bus_grant_i(bus_grant_i),
        .phi2_i(phi2_i), .cyc_wr_i(cyc_wr_i), .addr_oe(addr_oe), .data_oe(data_oe),
        .rw_oe(rw_oe), .rw_o(rw_o), .stall_o(stall_o)
    );

    function automatic logic exp_owned();
        return m_own && bus_grant_i;
    endfunction

    function automatic logic [DW-1:0] exp_data();
        return (exp_owned() && cyc_wr_i && phi2_i) ? '1 : '0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R2/R3/R5 stall"}, 32'(stall_o), 32'(m_stall));
        chk({tag, " R6/R7/R10 addr_oe"}, 32'(addr_oe), exp_owned() ? 32'hFFFF : 32'h0);
        chk({tag, " R10 rw_oe"}, 32'(rw_oe), 32'(exp_owned()));
        chk({tag, " R9 data_oe"}, 32'(data_oe), 32'(exp_data()));
        chk({tag, " R8 rw_o"}, 32'(rw_o), 32'(!cyc_wr_i));
    endtask

    // drive at negedge, check, then advance model across the posedge
    task automatic step(input logic rdy, input logic gnt, input logic p2, input logic wr, input string tag);
        @(negedge clk);
        ready_i = rdy; bus_grant_i = gnt; phi2_i = p2; cyc_wr_i = wr;
        #1;
        check_all(tag);
        @(posedge clk);
        if (!p2) m_stall = !rdy && !wr;           // R2 R3 R5, held in phase 2 (R4)
        if (!gnt) m_own = 1'b0;                   // R6
        else if (p2) m_own = 1'b1;                // R7
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check_all("R1 reset");

        // R2 stall on read, R4 hold across phase 2
        step(1'b0, 1'b1, 1'b0, 1'b0, "R2 read");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R4 hold");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R2 still");
        // R5 release: ready back in phase 1 clears for following phase 2
        step(1'b1, 1'b1, 1'b1, 1'b0, "R4 stalled p2");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R5 release");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R5 completes");
        // R3 write during ready low
        step(1'b0, 1'b1, 1'b0, 1'b1, "R3 write");
        step(1'b0, 1'b1, 1'b1, 1'b1, "R3 write p2 R9");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R2 after write");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R2 stalled");
        // R6 grant drop regardless of ready, R7 return timing
        step(1'b0, 1'b0, 1'b0, 1'b1, "R6 drop");
        step(1'b1, 1'b0, 1'b1, 1'b1, "R6 off");
        step(1'b1, 1'b1, 1'b0, 1'b1, "R7 grant p1 still off");
        step(1'b1, 1'b1, 1'b1, 1'b1, "R7 grant p2 still off");
        step(1'b1, 1'b1, 1'b0, 1'b1, "R7 on at phase 1");
        step(1'b1, 1'b1, 1'b1, 1'b1, "R9 write drive");
        step(1'b1, 1'b0, 1'b1, 1'b1, "R6 drop in p2");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R7 off phase1");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R7 p2");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R7 on");

        // constrained random: phase alternates, grant mostly high
        for (int i = 0; i < 2000; i++) begin
            logic p2;
            p2 = (i % 2) == 1;
            step(($urandom % 4) != 0, ($urandom % 8) != 0, p2, $urandom % 2, "rand");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule